// File: doc/BRIEF.md
# Direct Page Address Generator

This unit computes the 24-bit operand address for the direct-page and stack-based operand fetches of an 8/16-bit processor. It also computes the addresses of the pointer bytes that the indirect modes read. The instruction sequencer supplies the following inputs for every fetch:

- the direct page base and the one-byte operand offset;
- the X and Y index values and the current index width;
- the emulation flag, and a flag that marks opcodes inherited from the older 8-bit family;
- a mode code;
- a byte step that selects which byte of a multi-byte operand or pointer is wanted.

The unit registers one address per strobe. The bank of every result is zero.

Whether an address stays inside one 256-byte page is decided jointly by three conditions. In-page wrap applies only when emulation is active, the opcode is a legacy one, and the low byte of the direct page base is zero. If any of these conditions fails, the unit adds the full 16 bits, and the result rolls over from $FFFF to $0000 without carrying into the bank.

Stack-based modes follow a simpler rule. When emulation is active and the opcode is legacy, the address is held in page $01. Otherwise the unit uses full 16-bit arithmetic.

Top module: `dp_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it, `out_valid` is 0 and `out_addr` and `out_bank` are 0.
- R2: `out_valid` is 1 in exactly the cycle after each rising edge where `in_valid` was 1. When `in_valid` is 0, `out_addr` keeps its previous value.
- R3: `out_bank` is always 8'h00.
- R4: In native mode (`emu`=0), the direct modes produce base + offset + index + step modulo 2^16. For example, base $2000, offset $20 and a 16-bit index of $0300 give $2320, and base $FFF0 with offset $20 gives $0010.
- R5: When `emu`=1, `legacy`=1 and the low byte of the base is $00, the direct modes keep the base high byte and replace the low byte with (offset + index + step) mod 256. For example, base $0000, offset $F0 and index $20 give $0010.
- R6: When `emu`=1 and `legacy`=1 but the low byte of the base is nonzero, the full 16-bit sum of R4 is used.
- R7: When `emu`=1 and `legacy`=0, the full 16-bit sum of R4 is used.
- R8: The index is used at 16 bits only when `idx_wide`=1 and `emu`=0. In every other case, only its low byte is used, zero-extended.
- R9: The `mode` codes are:
  - 0: direct;
  - 1: direct+X;
  - 2: direct+Y;
  - 3: pointer byte of the indirect and indirect-then-Y modes, formed like code 0;
  - 4: pointer byte of the X-then-indirect mode, formed like code 1;
  - 5: long-pointer byte;
  - 6: stack + offset;
  - 7: stack push, which gives the stack pointer minus step.
- R10: Mode 5 always uses the full 16-bit sum of base + offset + step, whatever the values of `emu` and `legacy`.
- R11: In modes 6 and 7, when `emu`=1 and `legacy`=1, the address is {8'h01, low byte of the stack result}. Otherwise the full 16-bit result is used. For example, a stack pointer of $0100 with a step of 1 gives $01FF.
- R12: Mode codes 8 to 15 give the same address as code 0.
- R13: `step` (0 to 3) is added to the address of each successive byte, and it is subject to the same wrap decision as the rest of the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that captures a new address |
| mode | input | 4 | Addressing mode code (R9) |
| emu | input | 1 | Emulation mode active |
| legacy | input | 1 | Opcode belongs to the older 8-bit instruction set |
| idx_wide | input | 1 | Index registers hold 16 bits |
| dp_reg | input | 16 | Direct page base |
| offset | input | 8 | Operand offset byte |
| x_idx | input | 16 | X index value |
| y_idx | input | 16 | Y index value |
| sp_reg | input | 16 | Stack pointer |
| step | input | 2 | Byte number within the operand or pointer |
| out_valid | output | 1 | One-cycle result strobe |
| out_bank | output | 8 | Result bank, always zero |
| out_addr | output | 16 | Result address |

## Verification
Every result appears one rising edge after the edge that sees `in_valid` high, because there is a single output register. The bench drives each vector at a falling edge and compares `out_addr`, `out_bank` and `out_valid` at the following falling edge, exactly one register stage later. After the strobe is dropped, the bench waits a further falling edge and checks both that `out_valid` has fallen and that the address has not moved. The sweep covers every mode code, both flags, both index widths, every step, and direct page bases with zero and nonzero low bytes. The expected values come from an arithmetic model in the bench.

// File: rtl/dpag_pkg.sv
package dpag_pkg;

    localparam int ADDR_W  = 16;
    localparam int PAGE_W  = 8;
    localparam int OFS_W   = 8;
    localparam int STEP_W  = 2;
    localparam int BANK_W  = 8;
    localparam int MODE_W  = 4;

    localparam logic [PAGE_W-1:0] STACK_PAGE = 8'h01;
    localparam logic [BANK_W-1:0] DP_BANK    = 8'h00;

    localparam logic [MODE_W-1:0] MD_DIR        = 4'd0;
    localparam logic [MODE_W-1:0] MD_DIRX       = 4'd1;
    localparam logic [MODE_W-1:0] MD_DIRY       = 4'd2;
    localparam logic [MODE_W-1:0] MD_PTR_IND    = 4'd3;
    localparam logic [MODE_W-1:0] MD_PTR_IDXIND = 4'd4;
    localparam logic [MODE_W-1:0] MD_PTR_LONG   = 4'd5;
    localparam logic [MODE_W-1:0] MD_STK_REL    = 4'd6;
    localparam logic [MODE_W-1:0] MD_STK_PUSH   = 4'd7;

    typedef enum logic [1:0] {
        IX_NONE = 2'd0,
        IX_X    = 2'd1,
        IX_Y    = 2'd2
    } idx_sel_e;

    typedef enum logic [1:0] {
        WR_DIRECT = 2'd0,
        WR_STACK  = 2'd1,
        WR_NEVER  = 2'd2
    } wrap_kind_e;

    // Decoded form of one mode code
    typedef struct packed {
        idx_sel_e   isel;
        wrap_kind_e wkind;
        logic       use_stack;
        logic       add_offset;
        logic       subtract_step;
    } mode_dec_t;

    // Operands handed to the adder stage
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addend;
        logic              wrap;
        logic [PAGE_W-1:0] page;
    } sum_req_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t d;
        d.isel          = IX_NONE;
        d.wkind         = WR_DIRECT;
        d.use_stack     = 1'b0;
        d.add_offset    = 1'b1;
        d.subtract_step = 1'b0;
        case (m)
            MD_DIR, MD_PTR_IND: ;
            MD_DIRX, MD_PTR_IDXIND: d.isel = IX_X;
            MD_DIRY: d.isel = IX_Y;
            MD_PTR_LONG: d.wkind = WR_NEVER;
            MD_STK_REL: begin
                d.use_stack = 1'b1;
                d.wkind     = WR_STACK;
            end
            MD_STK_PUSH: begin
                d.use_stack     = 1'b1;
                d.wkind         = WR_STACK;
                d.add_offset    = 1'b0;
                d.subtract_step = 1'b1;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dpag_wrap_ctl.sv
module dpag_wrap_ctl #(
    parameter int LOW_W = 8
) (
    input  logic             emu,
    input  logic             legacy,
    input  logic [LOW_W-1:0] dp_low,
    output logic             dp_wrap,
    output logic             stk_wrap
);
    logic legacy_emu;

    always_comb begin
        legacy_emu = emu & legacy;
        dp_wrap    = legacy_emu & ~(|dp_low);
        stk_wrap   = legacy_emu;
    end
endmodule

// File: rtl/dpag_index_sel.sv
module dpag_index_sel #(
    parameter int IDX_W    = 16,
    parameter int NARROW_W = 8
) (
    input  dpag_pkg::idx_sel_e isel,
    input  logic               wide,
    input  logic               emu,
    input  logic [IDX_W-1:0]   x_val,
    input  logic [IDX_W-1:0]   y_val,
    output logic [IDX_W-1:0]   idx_out
);
    import dpag_pkg::*;

    logic             full_width;
    logic [IDX_W-1:0] picked;

    always_comb begin
        full_width = wide & ~emu;
        case (isel)
            IX_X:    picked = x_val;
            IX_Y:    picked = y_val;
            default: picked = '0;
        endcase
        if (full_width)
            idx_out = picked;
        else
            idx_out = {{(IDX_W-NARROW_W){1'b0}}, picked[NARROW_W-1:0]};
    end
endmodule

// File: rtl/dpag_adder.sv
module dpag_adder #(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] addend,
    input  logic          wrap,
    input  logic [PW-1:0] page,
    output logic [AW-1:0] addr
);
    localparam int LW = AW - PW;

    logic [AW-1:0] full_sum;
    logic [LW-1:0] low_sum;

    always_comb begin
        full_sum = base + addend;
        low_sum  = base[LW-1:0] + addend[LW-1:0];
        addr     = wrap ? {page, low_sum} : full_sum;
    end
endmodule

// File: rtl/dp_addr_gen.sv
module dp_addr_gen #(
    parameter int AW = dpag_pkg::ADDR_W,
    parameter int PW = dpag_pkg::PAGE_W,
    parameter int OW = dpag_pkg::OFS_W,
    parameter int SW = dpag_pkg::STEP_W,
    parameter int BW = dpag_pkg::BANK_W,
    parameter int MW = dpag_pkg::MODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [MW-1:0] mode,
    input  logic          emu,
    input  logic          legacy,
    input  logic          idx_wide,
    input  logic [AW-1:0] dp_reg,
    input  logic [OW-1:0] offset,
    input  logic [AW-1:0] x_idx,
    input  logic [AW-1:0] y_idx,
    input  logic [AW-1:0] sp_reg,
    input  logic [SW-1:0] step,
    output logic          out_valid,
    output logic [BW-1:0] out_bank,
    output logic [AW-1:0] out_addr
);
    import dpag_pkg::*;

    localparam int LW = AW - PW;

    mode_dec_t     dec;
    logic          dp_wrap;
    logic          stk_wrap;
    logic [AW-1:0] idx_val;
    logic [AW-1:0] ofs_ext;
    logic [AW-1:0] step_ext;
    sum_req_t      req;
    logic [AW-1:0] next_addr;

    always_comb dec = decode_mode(mode);

    dpag_wrap_ctl #(.LOW_W(LW)) u_wrap (
        .emu      (emu),
        .legacy   (legacy),
        .dp_low   (dp_reg[LW-1:0]),
        .dp_wrap  (dp_wrap),
        .stk_wrap (stk_wrap)
    );

    dpag_index_sel #(.IDX_W(AW), .NARROW_W(LW)) u_idx (
        .isel    (dec.isel),
        .wide    (idx_wide),
        .emu     (emu),
        .x_val   (x_idx),
        .y_val   (y_idx),
        .idx_out (idx_val)
    );

    always_comb begin
        ofs_ext  = dec.add_offset ? AW'(offset) : '0;
        step_ext = AW'(step);
        req.base = dec.use_stack ? sp_reg : dp_reg;
        if (dec.subtract_step)
            req.addend = '0 - step_ext;
        else
            req.addend = ofs_ext + idx_val + step_ext;
        case (dec.wkind)
            WR_DIRECT: begin
                req.wrap = dp_wrap;
                req.page = dp_reg[AW-1:LW];
            end
            WR_STACK: begin
                req.wrap = stk_wrap;
                req.page = STACK_PAGE;
            end
            default: begin
                req.wrap = 1'b0;
                req.page = dp_reg[AW-1:LW];
            end
        endcase
    end

    dpag_adder #(.AW(AW), .PW(PW)) u_add (
        .base   (req.base),
        .addend (req.addend),
        .wrap   (req.wrap),
        .page   (req.page),
        .addr   (next_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bank  <= '0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            out_bank  <= BW'(DP_BANK);
            if (in_valid)
                out_addr <= next_addr;
        end
    end
endmodule

// File: rtl/dpag_checker.sv
module dpag_checker #(
    parameter int AW = 16,
    parameter int MW = 4,
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [MW-1:0] mode,
    input logic          emu,
    input logic          legacy,
    input logic [AW-1:0] dp_reg,
    input logic          out_valid,
    input logic [BW-1:0] out_bank,
    input logic [AW-1:0] out_addr
);
    localparam int LW = AW / 2;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2

    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_addr)); // R2

    AST_DP_PAGE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && emu && legacy && dp_reg[LW-1:0] == '0 && mode == 4'd0)
        |=> out_addr[AW-1:LW] == $past(dp_reg[AW-1:LW])); // R5

    AST_STACK_PAGE_ONE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && emu && legacy && (mode == 4'd6 || mode == 4'd7))
        |=> out_addr[AW-1:LW] == 8'h01); // R11

    AST_BANK_ZERO_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> out_bank == '0); // R3
endmodule

bind dp_addr_gen dpag_checker #(.AW(AW), .MW(MW), .BW(BW)) u_dpag_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .emu       (emu),
    .legacy    (legacy),
    .dp_reg    (dp_reg),
    .out_valid (out_valid),
    .out_bank  (out_bank),
    .out_addr  (out_addr)
);

// File: tb/dp_addr_gen_bench.sv
module dp_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic        emu = 1'b0;
    logic        legacy = 1'b0;
    logic        idx_wide = 1'b0;
    logic [15:0] dp_reg = '0;
    logic [7:0]  offset = '0;
    logic [15:0] x_idx = '0;
    logic [15:0] y_idx = '0;
    logic [15:0] sp_reg = '0;
    logic [1:0]  step = '0;
    logic        out_valid;
    logic [7:0]  out_bank;
    logic [15:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dp_addr_gen u_dp_addr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .emu(emu),
        .legacy(legacy), .idx_wide(idx_wide), .dp_reg(dp_reg), .offset(offset),
        .x_idx(x_idx), .y_idx(y_idx), .sp_reg(sp_reg), .step(step),
        .out_valid(out_valid), .out_bank(out_bank), .out_addr(out_addr)
    );

    function automatic logic [15:0] model(
        input logic [3:0] m, input bit e, input bit lg, input bit w,
        input logic [15:0] dp, input logic [7:0] ofs, input logic [15:0] xv,
        input logic [15:0] yv, input logic [15:0] sp, input logic [1:0] st);
        logic [15:0] xs, ys, ix, s;
        bit dwrap, swrap;
        dwrap = e && lg && (dp[7:0] == 8'h00);
        swrap = e && lg;
        xs = (w && !e) ? xv : {8'h00, xv[7:0]};
        ys = (w && !e) ? yv : {8'h00, yv[7:0]};
        ix = 16'h0000;
        case (m)
            4'd1, 4'd4: ix = xs;
            4'd2:       ix = ys;
            4'd5:       return dp + {8'h00, ofs} + {14'h0, st};
            4'd6: begin
                s = sp + {8'h00, ofs} + {14'h0, st};
                return swrap ? {8'h01, s[7:0]} : s;
            end
            4'd7: begin
                s = sp - {14'h0, st};
                return swrap ? {8'h01, s[7:0]} : s;
            end
            default: ix = 16'h0000;
        endcase
        s = dp + {8'h00, ofs} + ix + {14'h0, st};
        return dwrap ? {dp[15:8], s[7:0]} : s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] m, input bit e, input bit lg, input bit w,
                         input logic [15:0] dp, input logic [7:0] ofs, input logic [15:0] xv,
                         input logic [15:0] yv, input logic [15:0] sp, input logic [1:0] st);
        mode = m; emu = e; legacy = lg; idx_wide = w; dp_reg = dp; offset = ofs;
        x_idx = xv; y_idx = yv; sp_reg = sp; step = st; in_valid = 1'b1;
    endtask

    // One vector: drive at a falling edge, result due after the next rising edge
    task automatic one(input string tag, input logic [3:0] m, input bit e, input bit lg,
                       input bit w, input logic [15:0] dp, input logic [7:0] ofs,
                       input logic [15:0] xv, input logic [15:0] yv, input logic [15:0] sp,
                       input logic [1:0] st, input logic [15:0] expv);
        @(negedge clk);
        drive(m, e, lg, w, dp, ofs, xv, yv, sp, st);
        @(negedge clk);
        check(tag, {16'h0, out_addr}, {16'h0, expv});
        check({tag, " R3 bank"}, {24'h0, out_bank}, 32'h0);
        check({tag, " R2 valid"}, {31'h0, out_valid}, 32'h1);
    endtask

    function automatic string tag_for(input logic [3:0] m, input bit e, input bit lg,
                                      input logic [15:0] dp);
        if (m >= 4'd8) return "R12";
        if (m == 4'd5) return "R10";
        if (m == 4'd6 || m == 4'd7) return "R11";
        if (e && lg && dp[7:0] == 8'h00) return "R5";
        if (e && lg) return "R6";
        if (e) return "R7";
        return "R4 R9 R13";
    endfunction

    initial begin
        logic [15:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid", {31'h0, out_valid}, 32'h0);
        check("R1 addr", {16'h0, out_addr}, 32'h0);
        check("R1 bank", {24'h0, out_bank}, 32'h0);
        rst = 1'b0;

        // Directed corner cases
        one("R5 zero page wrap", 4'd1, 1, 1, 0, 16'h0000, 8'hF0, 16'h0020, 16'h0, 16'h01FF, 2'd0, 16'h0010);
        one("R4 native no wrap", 4'd1, 0, 1, 1, 16'h2000, 8'h20, 16'h0300, 16'h0, 16'h01FF, 2'd0, 16'h2320);
        one("R4 rollover no bank carry", 4'd0, 0, 0, 0, 16'hFFF0, 8'h20, 16'h0, 16'h0, 16'h0, 2'd0, 16'h0010);
        one("R6 low byte nonzero", 4'd1, 1, 1, 0, 16'h0001, 8'hF0, 16'h0020, 16'h0, 16'h0, 2'd0, 16'h0111);
        one("R7 new opcode in emu", 4'd1, 1, 0, 0, 16'h0000, 8'hF0, 16'h0020, 16'h0, 16'h0, 2'd0, 16'h0110);
        one("R8 narrow index native", 4'd1, 0, 0, 0, 16'h2000, 8'h20, 16'h0300, 16'h0, 16'h0, 2'd0, 16'h2020);
        one("R8 emu forces narrow", 4'd2, 1, 0, 1, 16'h2000, 8'h20, 16'h0, 16'h0305, 16'h0, 2'd0, 16'h2025);
        one("R9 Y mode", 4'd2, 0, 0, 1, 16'h1000, 8'h01, 16'h0, 16'h0100, 16'h0, 2'd0, 16'h1101);
        one("R13 step wraps in page", 4'd3, 1, 1, 0, 16'h0300, 8'hFF, 16'h0, 16'h0, 16'h0, 2'd1, 16'h0300);
        one("R10 long pointer no wrap", 4'd5, 1, 1, 0, 16'h0000, 8'hFF, 16'h0, 16'h0, 16'h0, 2'd2, 16'h0101);
        one("R11 push wraps in page one", 4'd7, 1, 1, 0, 16'h0, 8'h0, 16'h0, 16'h0, 16'h0100, 2'd1, 16'h01FF);
        one("R11 push native", 4'd7, 0, 1, 0, 16'h0, 8'h0, 16'h0, 16'h0, 16'h0100, 2'd1, 16'h00FF);
        one("R12 undefined code", 4'd13, 0, 0, 1, 16'h2000, 8'h20, 16'h0300, 16'h0300, 16'h0, 2'd0, 16'h2020);

        // R2: strobe low holds the address and drops valid
        @(negedge clk);
        held = out_addr;
        in_valid = 1'b0;
        dp_reg = 16'h4444;
        offset = 8'h77;
        @(negedge clk);
        check("R2 valid low", {31'h0, out_valid}, 32'h0);
        check("R2 addr held", {16'h0, out_addr}, {16'h0, held});
        @(negedge clk);
        check("R2 addr still held", {16'h0, out_addr}, {16'h0, held});

        // Sweep, one vector per cycle
        for (int di = 0; di < 5; di++) begin
            for (int oi = 0; oi < 4; oi++) begin
                for (int xi = 0; xi < 3; xi++) begin
                    for (int si = 0; si < 2; si++) begin
                        for (int m = 0; m < 16; m++) begin
                            for (int f = 0; f < 8; f++) begin
                                for (int st = 0; st < 4; st++) begin
                                    logic [15:0] dpv, xv, spv;
                                    logic [7:0]  ov;
                                    case (di)
                                        0: dpv = 16'h0000;
                                        1: dpv = 16'h2000;
                                        2: dpv = 16'h12FF;
                                        3: dpv = 16'hFF00;
                                        default: dpv = 16'hFFF3;
                                    endcase
                                    case (oi)
                                        0: ov = 8'h00;
                                        1: ov = 8'hF0;
                                        2: ov = 8'hFF;
                                        default: ov = 8'h7F;
                                    endcase
                                    case (xi)
                                        0: xv = 16'h0020;
                                        1: xv = 16'h0300;
                                        default: xv = 16'hFFFF;
                                    endcase
                                    spv = (si == 0) ? 16'h0100 : 16'h1281;
                                    one(tag_for(4'(m), f[2], f[1], dpv), 4'(m), f[2], f[1], f[0],
                                        dpv, ov, xv, xv ^ 16'h0181, spv, 2'(st),
                                        model(4'(m), f[2], f[1], f[0], dpv, ov, xv,
                                              xv ^ 16'h0181, spv, 2'(st)));
                                end
                            end
                        end
                    end
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule